// File: doc/BRIEF.md
# Bus Transfer Protocol Monitor with Coverage Counters

This block sits passively beside a simple non-pipelined bus with one target. It watches the target select, the enable strobe, the write flag, the address and the write data, and it never drives the bus. On every clock it decides which bus phase the current inputs show. It checks that phase against the phase of the previous clock. When a step is not allowed, or when address, direction or write data change between the setup phase and the enable phase, it raises a sticky error flag and keeps a code for the first fault.

The block also gathers coverage in hardware. It counts read and write transfers separately. It sorts runs of back-to-back transfers into singles and bursts, keeps the longest run seen, and records hits on the all-zeros and all-ones addresses. A small index port reads each value back on the next clock. A synchronous clear strobe zeroes every count, flag and error.

The phase tracker has three states:
- IDLE: select is low.
- SETUP: select is high and enable is low.
- XFER: both select and enable are high.

Each clock, the next state is the phase that the bus inputs show. The one exception is enable high with select low, which is treated as IDLE.

The legal transitions are:
- IDLE→IDLE
- IDLE→SETUP
- SETUP→XFER, which is a transfer
- XFER→SETUP, which continues a burst
- XFER→IDLE

The illegal transitions are:
- IDLE→XFER
- SETUP→SETUP
- SETUP→IDLE
- XFER→XFER
- enable high while select is low, from any state

Top module: `busmon`

## Requirements
- R1: `bus_phase` shows the phase sampled at the last clock edge, encoded 0 for IDLE, 1 for SETUP and 2 for XFER. Enable high with select low is recorded as IDLE.
- R2: A transfer is a clock with select and enable both high that directly follows a SETUP clock. Read transfers (write flag 0) are counted at index 0 and write transfers at index 1.
- R3: An illegal transition sets `err_flag` and latches a code: 1 for enable without select, 2 for IDLE→XFER, 3 for SETUP held, 4 for XFER held, 5 for SETUP→IDLE. The flag and the first code are kept until clear, and later errors do not change the code.
- R4: In a transfer clock, if the address, the write flag or the write data differ from the values of the SETUP clock before it, error code 6 is latched under the rules of R3.
- R5: A run is a series of transfers with no IDLE clock between them. When the bus returns to IDLE, a run of one transfer adds one to the single count and a longer run adds one to the burst count. The direction is taken from the first transfer of the run. The indices are: 2 single read, 3 single write, 4 burst read, 5 burst write.
- R6: Index 8 holds the largest run length reached since the last clear. It is updated at every transfer.
- R7: Index 9 holds sticky address hits for transfers: bit0 all-zeros read, bit1 all-ones read, bit2 all-zeros write, bit3 all-ones write.
- R8: Transfers whose address is neither all zeros nor all ones are counted at index 6 for reads and index 7 for writes.
- R9: Every counter, including the run length, stops at its all-ones value and does not wrap.
- R10: `clr` zeroes all counters, the longest run, the address bits and the error state at that edge, and wins over an event in the same clock. Phase tracking and the run in progress are unaffected.
- R11: `reg_val` returns, one clock after `reg_idx`, the selected value. Index 10 reads as {code, flag} in bits 3:0. Indices 11 and up read 0.
- R12: After reset, the phase is IDLE and every count, bit and error reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of coverage and error state |
| sel | input | 1 | Bus target select |
| en | input | 1 | Bus enable strobe |
| wr | input | 1 | Bus write flag (1 = write) |
| addr | input | AW | Bus address |
| wdata | input | DW | Bus write data |
| reg_idx | input | IW | Readback index |
| reg_val | output | CW | Readback value, one clock after index |
| bus_phase | output | 2 | Sampled bus phase |
| err_flag | output | 1 | Sticky protocol error |
| err_code | output | 3 | Code of the first error since clear |

## Verification
A clear can land in the same clock as a completed transfer. In that case the transfer's increments to the counts, the longest run and the address bits must be dropped, while the run it belongs to keeps going. The bench drives a transfer clock with `clr` high, then returns the bus to IDLE, and expects every count to be zero except one single of that transfer's direction, with the longest run still 0. A second overlap is a new error arriving while an earlier one is held; the bench checks that the first code survives.

// File: rtl/busmon_pkg.sv
package busmon_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_XFER  = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        ERR_NONE         = 3'd0,
        ERR_EN_NO_SEL    = 3'd1,
        ERR_IDLE_TO_XFER = 3'd2,
        ERR_SETUP_HELD   = 3'd3,
        ERR_XFER_HELD    = 3'd4,
        ERR_SETUP_DROP   = 3'd5,
        ERR_UNSTABLE     = 3'd6
    } err_e;

    localparam int NUM_EVT    = 8;
    localparam int IX_RD      = 0;
    localparam int IX_WR      = 1;
    localparam int IX_SGL_RD  = 2;
    localparam int IX_SGL_WR  = 3;
    localparam int IX_BST_RD  = 4;
    localparam int IX_BST_WR  = 5;
    localparam int IX_MID_RD  = 6;
    localparam int IX_MID_WR  = 7;
    localparam int IX_MAXRUN  = 8;
    localparam int IX_BOUND   = 9;
    localparam int IX_ERR     = 10;
endpackage

// File: rtl/busmon_satcnt.sv
module busmon_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && (cnt != '1))
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/busmon_phase.sv
module busmon_phase
    import busmon_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          sel,
    input  logic          en,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output phase_e        phase_q,
    output logic          xfer,
    output logic          to_idle,
    output logic          err_flag_q,
    output err_e          err_code_q
);
    phase_e        cls;
    phase_e        next_ph;
    err_e          hit;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          wr_q;

    always_comb begin
        if (sel && en)
            cls = PH_XFER;
        else if (sel)
            cls = PH_SETUP;
        else
            cls = PH_IDLE;
    end

    always_comb begin
        next_ph = cls;
        xfer    = 1'b0;
        hit     = ERR_NONE;
        if (!sel && en) begin
            hit = ERR_EN_NO_SEL;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (cls == PH_XFER) hit = ERR_IDLE_TO_XFER;
                end
                PH_SETUP: begin
                    unique case (cls)
                        PH_SETUP: hit = ERR_SETUP_HELD;
                        PH_IDLE:  hit = ERR_SETUP_DROP;
                        PH_XFER: begin
                            xfer = 1'b1;
                            if (addr != addr_q || wr != wr_q || wdata != wdata_q)
                                hit = ERR_UNSTABLE;
                        end
                        default: hit = ERR_NONE;
                    endcase
                end
                PH_XFER: begin
                    if (cls == PH_XFER) hit = ERR_XFER_HELD;
                end
                default: hit = ERR_NONE;
            endcase
        end
        to_idle = (cls == PH_IDLE) && (phase_q != PH_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else begin
            phase_q <= next_ph;
            addr_q  <= addr;
            wdata_q <= wdata;
            wr_q    <= wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag_q <= 1'b0;
            err_code_q <= ERR_NONE;
        end else if (clr) begin
            err_flag_q <= 1'b0;
            err_code_q <= ERR_NONE;
        end else if (!err_flag_q && hit != ERR_NONE) begin
            err_flag_q <= 1'b1;
            err_code_q <= hit;
        end
    end
endmodule

// File: rtl/busmon_cov.sv
module busmon_cov
    import busmon_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          xfer,
    input  logic          to_idle,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output logic [CW-1:0] evt_cnt [NUM_EVT],
    output logic [CW-1:0] max_run_q,
    output logic [3:0]    bound_q
);
    logic [NUM_EVT-1:0] inc;
    logic [CW-1:0]      run_len_q;
    logic [CW-1:0]      run_len_nx;
    logic               run_wr_q;
    logic               is_lo;
    logic               is_hi;
    logic               is_sgl;
    logic               is_bst;

    assign is_lo      = (addr == '0);
    assign is_hi      = (addr == '1);
    assign run_len_nx = (run_len_q == '1) ? run_len_q : run_len_q + 1'b1;
    assign is_sgl     = to_idle && (run_len_q == CW'(1));
    assign is_bst     = to_idle && (run_len_q > CW'(1));

    always_comb begin
        inc            = '0;
        inc[IX_RD]     = xfer && !wr;
        inc[IX_WR]     = xfer && wr;
        inc[IX_SGL_RD] = is_sgl && !run_wr_q;
        inc[IX_SGL_WR] = is_sgl && run_wr_q;
        inc[IX_BST_RD] = is_bst && !run_wr_q;
        inc[IX_BST_WR] = is_bst && run_wr_q;
        inc[IX_MID_RD] = xfer && !wr && !is_lo && !is_hi;
        inc[IX_MID_WR] = xfer && wr && !is_lo && !is_hi;
    end

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_cnt
        busmon_satcnt #(.W(CW)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr),
            .inc  (inc[g]),
            .cnt  (evt_cnt[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len_q <= '0;
            run_wr_q  <= 1'b0;
        end else if (xfer) begin
            run_len_q <= run_len_nx;
            if (run_len_q == '0) run_wr_q <= wr;
        end else if (to_idle) begin
            run_len_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            max_run_q <= '0;
            bound_q   <= '0;
        end else if (clr) begin
            max_run_q <= '0;
            bound_q   <= '0;
        end else if (xfer) begin
            if (run_len_nx > max_run_q) max_run_q <= run_len_nx;
            if (is_lo) bound_q[wr ? 2 : 0] <= 1'b1;
            if (is_hi) bound_q[wr ? 3 : 1] <= 1'b1;
        end
    end
endmodule

// File: rtl/busmon.sv
module busmon
    import busmon_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          sel,
    input  logic          en,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] reg_idx,
    output logic [CW-1:0] reg_val,
    output logic [1:0]    bus_phase,
    output logic          err_flag,
    output logic [2:0]    err_code
);
    phase_e        phase_q;
    err_e          err_code_q;
    logic          xfer;
    logic          to_idle;
    logic [CW-1:0] evt_cnt [NUM_EVT];
    logic [CW-1:0] max_run_q;
    logic [3:0]    bound_q;

    busmon_phase #(.AW(AW), .DW(DW)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .sel       (sel),
        .en        (en),
        .wr        (wr),
        .addr      (addr),
        .wdata     (wdata),
        .phase_q   (phase_q),
        .xfer      (xfer),
        .to_idle   (to_idle),
        .err_flag_q(err_flag),
        .err_code_q(err_code_q)
    );

    busmon_cov #(.AW(AW), .CW(CW)) u_cov (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .xfer     (xfer),
        .to_idle  (to_idle),
        .wr       (wr),
        .addr     (addr),
        .evt_cnt  (evt_cnt),
        .max_run_q(max_run_q),
        .bound_q  (bound_q)
    );

    assign bus_phase = phase_q;
    assign err_code  = err_code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_val <= '0;
        end else if (int'(reg_idx) < NUM_EVT) begin
            reg_val <= evt_cnt[int'(reg_idx) % NUM_EVT];
        end else if (int'(reg_idx) == IX_MAXRUN) begin
            reg_val <= max_run_q;
        end else if (int'(reg_idx) == IX_BOUND) begin
            reg_val <= CW'(bound_q);
        end else if (int'(reg_idx) == IX_ERR) begin
            reg_val <= CW'({err_code_q, err_flag});
        end else begin
            reg_val <= '0;
        end
    end
endmodule

// File: rtl/busmon_chk.sv
module busmon_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic          sel,
    input logic          en,
    input logic [1:0]    bus_phase,
    input logic          err_flag,
    input logic [2:0]    err_code,
    input logic [CW-1:0] rd_cnt,
    input logic [CW-1:0] max_run
);
    AST_SETUP_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !en) |=> (bus_phase == 2'd1)); // R1
    AST_EN_WITHOUT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sel && !clr) |=> err_flag); // R3
    AST_XFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase == 2'd2 && sel && en && !clr) |=> err_flag); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr) |=> err_flag); // R3
    AST_CODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr) |=> $stable(err_code)); // R3
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cnt == '1 && !clr) |=> (rd_cnt == '1)); // R9
    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!err_flag && err_code == 3'd0 && rd_cnt == '0 && max_run == '0)); // R10
endmodule

bind busmon busmon_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .sel      (sel),
    .en       (en),
    .bus_phase(bus_phase),
    .err_flag (err_flag),
    .err_code (err_code),
    .rd_cnt   (evt_cnt[0]),
    .max_run  (max_run_q)
);

// File: tb/busmon_tb.sv
module busmon_tb;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int CW = 4;
    localparam int IW = 4;
    localparam int MAXC = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          sel = 1'b0;
    logic          en = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [IW-1:0] reg_idx = '0;
    logic [CW-1:0] reg_val;
    logic [1:0]    bus_phase;
    logic          err_flag;
    logic [2:0]    err_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int   m_cnt [8];
    int   m_max;
    int   m_bnd;
    int   run_len;
    bit   run_wr;

    busmon #(.AW(AW), .DW(DW), .CW(CW), .IW(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .sel(sel), .en(en), .wr(wr),
        .addr(addr), .wdata(wdata), .reg_idx(reg_idx), .reg_val(reg_val),
        .bus_phase(bus_phase), .err_flag(err_flag), .err_code(err_code)
    );

    always #2 clk = ~clk;

    function automatic int sat(input int x);
        return (x > MAXC) ? MAXC : x;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input bit s, input bit e, input bit w,
                         input int a, input int d, input bit c);
        @(negedge clk);
        sel = s; en = e; wr = w; addr = AW'(a); wdata = DW'(d); clr = c;
        @(posedge clk);
        #1;
    endtask

    task automatic rd_reg(input int idx, output int v);
        @(negedge clk);
        sel = 1'b0; en = 1'b0; clr = 1'b0; reg_idx = IW'(idx);
        @(posedge clk);
        #1;
        v = int'(reg_val);
    endtask

    task automatic m_clear();
        foreach (m_cnt[i]) m_cnt[i] = 0;
        m_max = 0;
        m_bnd = 0;
    endtask

    task automatic m_xfer(input bit w, input int a);
        if (run_len == 0) run_wr = w;
        run_len = sat(run_len + 1);
        m_cnt[w ? 1 : 0] = sat(m_cnt[w ? 1 : 0] + 1);
        if (a == 0) m_bnd |= (w ? 4 : 1);
        else if (a == MAXC) m_bnd |= (w ? 8 : 2);
        else m_cnt[w ? 7 : 6] = sat(m_cnt[w ? 7 : 6] + 1);
        if (run_len > m_max) m_max = run_len;
    endtask

    task automatic m_end();
        if (run_len == 1) m_cnt[run_wr ? 3 : 2] = sat(m_cnt[run_wr ? 3 : 2] + 1);
        else if (run_len > 1) m_cnt[run_wr ? 5 : 4] = sat(m_cnt[run_wr ? 5 : 4] + 1);
        run_len = 0;
    endtask

    task automatic check_all(input string tag);
        int v;
        for (int i = 0; i < 8; i++) begin
            rd_reg(i, v);
            if (i < 2) chk({tag, " R2 transfer count"}, v, m_cnt[i]);
            else if (i < 6) chk({tag, " R5 single/burst count"}, v, m_cnt[i]);
            else chk({tag, " R8 mid-address count"}, v, m_cnt[i]);
        end
        rd_reg(8, v);  chk({tag, " R6 longest run"}, v, m_max);
        rd_reg(9, v);  chk({tag, " R7 boundary bits"}, v, m_bnd);
        rd_reg(10, v); chk({tag, " R11 error readback"}, v, 0);
    endtask

    task automatic do_run(input int n, input int dirs, input int a0, input bit chk_ph);
        for (int i = 0; i < n; i++) begin
            bit w = dirs[i];
            int a = (a0 + i) % 16;
            drive(1, 0, w, a, a * 3 + i, 0);
            if (chk_ph) chk("R1 phase after setup", bus_phase, 1);
            drive(1, 1, w, a, a * 3 + i, 0);
            m_xfer(w, a);
            if (chk_ph) chk("R1 phase after enable", bus_phase, 2);
        end
        drive(0, 0, 0, 0, 0, 0);
        m_end();
        if (chk_ph) chk("R1 phase after release", bus_phase, 0);
    endtask

    task automatic clear_all();
        drive(0, 0, 0, 0, 0, 1);
        m_clear();
        drive(0, 0, 0, 0, 0, 0);
    endtask

    task automatic err_expect(input string req, input int code);
        int v;
        chk({req, " err_flag"}, err_flag, 1);
        chk({req, " err_code"}, err_code, code);
        rd_reg(10, v);
        chk({req, " R11 error readback"}, v, code * 2 + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v;
        m_clear();
        run_len = 0;
        run_wr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R12 reset state
        chk("R12 phase after reset", bus_phase, 0);
        chk("R12 error after reset", err_flag, 0);
        check_all("R12");
        for (int i = 11; i < 16; i++) begin
            rd_reg(i, v);
            chk("R11 unused index", v, 0);
        end

        // R2 R5 R6 R7 R8 R9: sweep over run length and every direction pattern
        for (int n = 1; n <= 4; n++) begin
            for (int p = 0; p < (1 << n); p++) begin
                do_run(n, p, (n * 7 + p * 5) % 16, (n == 2));
                check_all("sweep");
            end
        end

        // R10 clear
        clear_all();
        check_all("R10 after clear");

        // R6 R9: long write burst saturates longest run and write count
        do_run(17, 32'h1FFFF, 1, 0);
        check_all("R9 long burst");
        chk("R9 longest run saturated", m_max, MAXC);

        // R10 clear in the same clock as a transfer
        clear_all();
        drive(1, 0, 1, 5, 9, 0);
        drive(1, 1, 1, 5, 9, 1);
        m_xfer(1, 5);
        m_clear();
        drive(0, 0, 0, 0, 0, 0);
        m_end();
        check_all("R10 clear vs transfer");
        chk("R10 single write survives", m_cnt[3], 1);

        // R3 error codes
        clear_all();
        drive(0, 1, 0, 0, 0, 0);
        chk("R1 enable-only phase", bus_phase, 0);
        err_expect("R3 enable without select", 1);
        clear_all();
        drive(1, 1, 0, 2, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        err_expect("R3 idle to xfer", 2);
        clear_all();
        drive(1, 0, 0, 2, 0, 0);
        drive(1, 0, 0, 2, 0, 0);
        drive(1, 1, 0, 2, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        err_expect("R3 setup held", 3);
        clear_all();
        drive(1, 0, 0, 2, 0, 0);
        drive(1, 1, 0, 2, 0, 0);
        drive(1, 1, 0, 2, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        err_expect("R3 xfer held", 4);
        clear_all();
        drive(1, 0, 0, 2, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        err_expect("R3 setup dropped", 5);
        drive(0, 1, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        err_expect("R3 first code kept", 5);

        // R4 stability
        clear_all();
        drive(1, 0, 1, 3, 7, 0);
        drive(1, 1, 1, 5, 7, 0);
        drive(0, 0, 0, 0, 0, 0);
        err_expect("R4 address change", 6);
        clear_all();
        drive(1, 0, 1, 3, 7, 0);
        drive(1, 1, 1, 3, 8, 0);
        drive(0, 0, 0, 0, 0, 0);
        err_expect("R4 data change", 6);
        clear_all();
        chk("R10 error cleared", err_flag, 0);
        run_len = 0;
        check_all("R10 final");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule